// File: doc/BRIEF.md
# Sequential Restoring Signed Divider

This block divides one signed two's complement number by another over several clock cycles. A request is accepted by pulsing `start` while the unit is idle. The block then takes the magnitudes of both operands and runs restoring long division on them. Each iteration shifts a partial remainder and quotient pair left by one place and tries to subtract the divisor. If the trial difference is negative, the partial remainder is put back and a 0 is shifted in. Otherwise the difference is kept and a 1 is shifted in.

Once all iterations are done, a sign correction stage applies truncating division rules. The remainder carries the dividend's sign, and the quotient is negated when the operand signs differ. The results and a divide-by-zero flag are registered together with a one-cycle `done` pulse. They stay unchanged until the next completion.

The parameter `STEPS` sets how many shift-subtract iterations are chained in one clock. This trades latency against combinational depth. It must divide `WIDTH` evenly.

Top module: `seq_div_signed`

## Requirements
- R1: After reset, `busy`, `done`, `div_zero`, `quotient` and `remainder` are all zero.
- R2: A `start` pulse seen while `busy` is low captures `dividend` and `divisor`. A `start` seen while `busy` is high is ignored, so the running operation completes with its original operands.
- R3: For a non-zero divisor, `done` is a one-cycle pulse that appears WIDTH/STEPS clock cycles after the accepting edge. `busy` is high for exactly those cycles and is low while `done` is high.
- R4: For a non-zero divisor, the magnitude of `quotient` is floor(|dividend| / |divisor|), and dividend = quotient × divisor + remainder holds with |remainder| < |divisor|.
- R5: The remainder is either zero or has the same sign as the dividend.
- R6: The quotient is negative exactly when the operand signs differ and the quotient is non-zero. For example, 7/3 gives (2, 1), 7/−3 gives (−2, 1), −7/3 gives (−2, −1) and −7/−3 gives (2, −1).
- R7: When |divisor| > |dividend|, the quotient is 0 and the remainder equals the dividend. When the operand magnitudes are equal, the quotient is ±1 and the remainder is 0.
- R8: A zero divisor makes `done` pulse at the accepting edge itself, without `busy` rising. It also sets `div_zero` to 1, `quotient` to all ones and `remainder` to the dividend. Every non-zero-divisor completion clears `div_zero`.
- R9: The most negative dividend divided by −1 wraps: the quotient is the most negative value and the remainder is 0.
- R10: `quotient`, `remainder` and `div_zero` change only on the edge that raises `done`, and hold their values in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a division; honoured only when idle |
| dividend | input | WIDTH | Signed dividend |
| divisor | input | WIDTH | Signed divisor |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse: results updated |
| quotient | output | WIDTH | Signed quotient, truncated toward zero |
| remainder | output | WIDTH | Signed remainder, sign of dividend |
| div_zero | output | 1 | Last completed request had a zero divisor |

## Verification
The bench builds two copies of the divider. One has WIDTH=4 and STEPS=2, with two iterations chained per clock. The 4-bit width keeps the whole operand space small, so all 256 operand pairs are run, including every zero divisor, the most-negative-by-minus-one wrap and every equal-magnitude pair. The other copy has WIDTH=8 and STEPS=1, which gives a long single-step run. It is used for random pairs, a start request injected mid-run and the latency count across eight iterations.

// File: rtl/seq_div_pkg.sv
package seq_div_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } div_state_e;

endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] value,
    output logic [WIDTH-1:0] mag,
    output logic             neg
);

    // The magnitude of the most negative value is 2^(WIDTH-1), which fits unsigned.
    always_comb begin
        neg = value[WIDTH-1];
        mag = neg ? (~value + 1'b1) : value;
    end

endmodule

// File: rtl/div_shift_sub.sv
module div_shift_sub #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] acc_in,
    input  logic [WIDTH-1:0] quo_in,
    input  logic [WIDTH-1:0] dsr,
    output logic [WIDTH-1:0] acc_out,
    output logic [WIDTH-1:0] quo_out
);

    logic [WIDTH:0] acc_sh;
    logic [WIDTH:0] trial;

    // The shifted partial remainder needs one extra bit.
    // The sign of the trial difference is read from that top bit.
    always_comb begin
        acc_sh = {acc_in, quo_in[WIDTH-1]};
        trial  = acc_sh - {1'b0, dsr};
        if (trial[WIDTH]) begin
            acc_out = acc_sh[WIDTH-1:0];
            quo_out = {quo_in[WIDTH-2:0], 1'b0};
        end else begin
            acc_out = trial[WIDTH-1:0];
            quo_out = {quo_in[WIDTH-2:0], 1'b1};
        end
    end

endmodule

// File: rtl/div_sign_fix.sv
module div_sign_fix #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] quo_mag,
    input  logic [WIDTH-1:0] rem_mag,
    input  logic             neg_quo,
    input  logic             neg_rem,
    output logic [WIDTH-1:0] quo_signed,
    output logic [WIDTH-1:0] rem_signed
);

    // Negation wraps modulo 2^WIDTH.
    always_comb begin
        quo_signed = neg_quo ? (~quo_mag + 1'b1) : quo_mag;
        rem_signed = neg_rem ? (~rem_mag + 1'b1) : rem_mag;
    end

endmodule

// File: rtl/seq_div_signed.sv
module seq_div_signed
    import seq_div_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int STEPS = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] quotient,
    output logic [WIDTH-1:0] remainder,
    output logic             div_zero
);

    localparam int ITERS = WIDTH / STEPS;
    localparam int CNT_W = (ITERS > 1) ? $clog2(ITERS) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ITERS - 1);

    typedef struct packed {
        div_state_e       st;
        logic [WIDTH-1:0] acc;
        logic [WIDTH-1:0] quo;
        logic [WIDTH-1:0] dsr;
        logic [CNT_W-1:0] cnt;
        logic             neg_quo;
        logic             neg_rem;
        logic             done;
        logic             dz;
        logic [WIDTH-1:0] quo_res;
        logic [WIDTH-1:0] rem_res;
    } div_regs_t;

    div_regs_t r_q, r_d;

    logic [WIDTH-1:0] dvd_mag, dvs_mag;
    logic             dvd_neg, dvs_neg;
    logic [WIDTH-1:0] fix_quo, fix_rem;

    logic [WIDTH-1:0] acc_chain [0:STEPS];
    logic [WIDTH-1:0] quo_chain [0:STEPS];

    div_operand_prep #(.WIDTH(WIDTH)) u_prep_dvd (
        .value (dividend),
        .mag   (dvd_mag),
        .neg   (dvd_neg)
    );

    div_operand_prep #(.WIDTH(WIDTH)) u_prep_dvs (
        .value (divisor),
        .mag   (dvs_mag),
        .neg   (dvs_neg)
    );

    assign acc_chain[0] = r_q.acc;
    assign quo_chain[0] = r_q.quo;

    // STEPS iterations are chained inside one clock cycle.
    for (genvar g = 0; g < STEPS; g++) begin : g_step
        div_shift_sub #(.WIDTH(WIDTH)) u_step (
            .acc_in  (acc_chain[g]),
            .quo_in  (quo_chain[g]),
            .dsr     (r_q.dsr),
            .acc_out (acc_chain[g+1]),
            .quo_out (quo_chain[g+1])
        );
    end

    div_sign_fix #(.WIDTH(WIDTH)) u_fix (
        .quo_mag    (quo_chain[STEPS]),
        .rem_mag    (acc_chain[STEPS]),
        .neg_quo    (r_q.neg_quo),
        .neg_rem    (r_q.neg_rem),
        .quo_signed (fix_quo),
        .rem_signed (fix_rem)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    if (divisor == '0) begin
                        r_d.done    = 1'b1;
                        r_d.dz      = 1'b1;
                        r_d.quo_res = '1;
                        r_d.rem_res = dividend;
                    end else begin
                        r_d.st      = ST_RUN;
                        r_d.acc     = '0;
                        r_d.quo     = dvd_mag;
                        r_d.dsr     = dvs_mag;
                        r_d.cnt     = '0;
                        r_d.neg_quo = dvd_neg ^ dvs_neg;
                        r_d.neg_rem = dvd_neg;
                    end
                end
            end
            ST_RUN: begin
                r_d.acc = acc_chain[STEPS];
                r_d.quo = quo_chain[STEPS];
                r_d.cnt = r_q.cnt + 1'b1;
                if (r_q.cnt == LAST_CNT) begin
                    r_d.st      = ST_IDLE;
                    r_d.done    = 1'b1;
                    r_d.dz      = 1'b0;
                    r_d.quo_res = fix_quo;
                    r_d.rem_res = fix_rem;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.st == ST_RUN);
    assign done      = r_q.done;
    assign quotient  = r_q.quo_res;
    assign remainder = r_q.rem_res;
    assign div_zero  = r_q.dz;

    // R3
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done);

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (r_q.cnt <= LAST_CNT));

    // R2
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && divisor != '0) |=> busy);

    // R4
    partial_below_divisor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (r_q.acc < r_q.dsr));

    // R8
    dz_all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_zero) |-> (quotient == '1));

    // R10
    results_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(quotient) && $stable(remainder) && $stable(div_zero)));

endmodule

// File: tb/test_seq_div_signed.sv
module div_harness #(
    parameter int WIDTH   = 4,
    parameter int STEPS   = 2,
    parameter bit EXHAUST = 1'b1,
    parameter int NRAND   = 0
) (
    input  logic clk,
    input  logic rst_n,
    output int   total,
    output int   bad,
    output logic fin
);

    localparam int ITERS = WIDTH / STEPS;

    typedef struct {
        logic [WIDTH-1:0] a;
        logic [WIDTH-1:0] b;
        logic [WIDTH-1:0] q;
        logic [WIDTH-1:0] r;
        logic             dz;
        int               cyc;
        string            tag;
    } exp_t;

    logic             start;
    logic [WIDTH-1:0] dividend, divisor;
    logic             busy, done, div_zero;
    logic [WIDTH-1:0] quotient, remainder;

    exp_t sb[$];
    int   cyc;
    int   d_total, d_bad, m_total, m_bad;
    logic done_last;

    assign total = d_total + m_total;
    assign bad   = d_bad + m_bad;

    seq_div_signed #(.WIDTH(WIDTH), .STEPS(STEPS)) i_seq_div_signed (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .dividend  (dividend),
        .divisor   (divisor),
        .busy      (busy),
        .done      (done),
        .quotient  (quotient),
        .remainder (remainder),
        .div_zero  (div_zero)
    );

    initial cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [WIDTH-1:0] sv(input int x);
        return x[WIDTH-1:0];
    endfunction

    function automatic exp_t model(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b);
        exp_t e;
        int ai, bi, qi, ri;
        ai = $signed(a);
        bi = $signed(b);
        e.a = a;
        e.b = b;
        if (bi == 0) begin
            e.q = '1;
            e.r = a;
            e.dz = 1'b1;
            e.tag = "R8";
        end else begin
            qi = ai / bi;
            ri = ai % bi;
            e.q = qi[WIDTH-1:0];
            e.r = ri[WIDTH-1:0];
            e.dz = 1'b0;
            if (ai == -(1 << (WIDTH-1)) && bi == -1) e.tag = "R9";
            else if ((ai < 0 ? -ai : ai) <= (bi < 0 ? -bi : bi)) e.tag = "R7";
            else if ((ai < 0) != (bi < 0)) e.tag = "R6";
            else if (ai < 0) e.tag = "R5";
            else e.tag = "R4";
        end
        return e;
    endfunction

    task automatic chk_d(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        d_total++;
        if (!ok) begin
            d_bad++;
            $display("FAIL %s W=%0d %s: actual=%0h expected=%0h", tag, WIDTH, what, act, exp);
        end
    endtask

    task automatic chk_m(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        m_total++;
        if (!ok) begin
            m_bad++;
            $display("FAIL %s W=%0d %s: actual=%0h expected=%0h", tag, WIDTH, what, act, exp);
        end
    endtask

    // Scoreboard monitor
    initial begin
        m_total = 0;
        m_bad = 0;
        done_last = 1'b0;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (done && done_last && !$past(start))
                chk_m(1'b0, "R3", "done longer than one cycle", 64'(done), 64'(0));
            if (done) begin
                if (sb.size() == 0) begin
                    chk_m(1'b0, "R3", "done with nothing pending", 64'(done), 64'(0));
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk_m(quotient == e.q, e.tag, "quotient", 64'(quotient), 64'(e.q));
                    chk_m(remainder == e.r, e.tag, "remainder", 64'(remainder), 64'(e.r));
                    chk_m(div_zero == e.dz, "R8", "div_zero flag", 64'(div_zero), 64'(e.dz));
                    chk_m(cyc == e.cyc, "R3", "done cycle", 64'(cyc), 64'(e.cyc));
                    chk_m(!busy, "R3", "busy during done", 64'(busy), 64'(0));
                end
            end
            done_last = done;
        end
    end

    task automatic issue(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                         input bit intrude, input string tag_ov);
        exp_t e;
        while (busy) @(negedge clk);
        e = model(a, b);
        if (tag_ov != "") e.tag = tag_ov;
        e.cyc = cyc + 1 + ((b == '0) ? 0 : ITERS);
        sb.push_back(e);
        dividend = a;
        divisor  = b;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (intrude) begin
            // R2: a second request while busy must be dropped
            chk_d(busy == 1'b1, "R2", "busy after accept", 64'(busy), 64'(1));
            dividend = ~a;
            divisor  = b + 1'b1;
            start    = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        fin = 1'b0;
        d_total = 0;
        d_bad = 0;
        start = 1'b0;
        dividend = '0;
        divisor = '0;
        @(negedge clk);
        while (!rst_n) @(negedge clk);

        // R1: reset state
        chk_d(!busy, "R1", "busy", 64'(busy), 64'(0));
        chk_d(!done, "R1", "done", 64'(done), 64'(0));
        chk_d(!div_zero, "R1", "div_zero", 64'(div_zero), 64'(0));
        chk_d(quotient == '0, "R1", "quotient", 64'(quotient), 64'(0));
        chk_d(remainder == '0, "R1", "remainder", 64'(remainder), 64'(0));

        // R6 sign examples
        issue(sv(7), sv(3), 1'b0, "R6");
        // R10: results hold after done
        repeat (3) @(negedge clk);
        chk_d(quotient == sv(2), "R10", "held quotient", 64'(quotient), 64'(sv(2)));
        chk_d(remainder == sv(1), "R10", "held remainder", 64'(remainder), 64'(sv(1)));
        issue(sv(7), sv(-3), 1'b0, "R6");
        issue(sv(-7), sv(3), 1'b0, "R6");
        issue(sv(-7), sv(-3), 1'b0, "R6");

        // R7 corner cases
        issue(sv(3), sv(7), 1'b0, "R7");
        issue(sv(-3), sv(5), 1'b0, "R7");
        issue(sv(5), sv(5), 1'b0, "R7");
        issue(sv(-5), sv(5), 1'b0, "R7");

        // R8 zero divisor, then a normal division clears the flag
        issue(sv(-6), sv(0), 1'b0, "R8");
        chk_d(!busy, "R8", "busy after zero divisor", 64'(busy), 64'(0));
        issue(sv(6), sv(2), 1'b0, "R8");

        // R9 wrap
        issue(sv(-(1 << (WIDTH-1))), sv(-1), 1'b0, "R9");

        // R2 start while busy is ignored
        issue(sv(7), sv(2), 1'b1, "R2");
        issue(sv(-5), sv(-2), 1'b1, "R2");

        if (EXHAUST) begin
            for (int i = 0; i < (1 << WIDTH); i++) begin
                for (int j = 0; j < (1 << WIDTH); j++) begin
                    issue(sv(i), sv(j), 1'b0, "");
                end
            end
        end
        for (int k = 0; k < NRAND; k++) begin
            int ra, rb;
            ra = int'($urandom());
            rb = int'($urandom());
            if (k % 7 == 0) rb = rb % 4 - 2;
            issue(sv(ra), sv(rb), 1'b0, "");
        end

        repeat (2) @(negedge clk);
        chk_d(sb.size() == 0, "R3", "pending results", 64'(sb.size()), 64'(0));
        fin = 1'b1;
    end

endmodule

module test_seq_div_signed;

    logic clk;
    logic rst_n;
    int   t4, b4, t8, b8;
    logic fin4, fin8;
    logic timeout;

    initial clk = 1'b0;
    always #2 clk = ~clk;

    div_harness #(.WIDTH(4), .STEPS(2), .EXHAUST(1'b1), .NRAND(0)) h_w4 (
        .clk (clk), .rst_n (rst_n), .total (t4), .bad (b4), .fin (fin4)
    );

    div_harness #(.WIDTH(8), .STEPS(1), .EXHAUST(1'b0), .NRAND(300)) h_w8 (
        .clk (clk), .rst_n (rst_n), .total (t8), .bad (b8), .fin (fin8)
    );

    initial begin
        timeout = 1'b0;
        repeat (150000) @(posedge clk);
        timeout = 1'b1;
    end

    initial begin
        int tot, nbad;
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        wait ((fin4 && fin8) || timeout);
        @(negedge clk);
        tot  = t4 + t8;
        nbad = b4 + b8;
        if (timeout) begin
            tot++;
            nbad++;
            $display("FAIL watchdog: actual=expired expected=finished");
        end
        $display("  test done: total=%0d bad=%0d", tot, nbad);
        $finish;
    end

endmodule